// File: doc/BRIEF.md
# Threshold Gate Output Generator

This block drives one digital gate output for a counter channel. On every clock it compares the channel's unsigned count against two programmable thresholds, `lo` (threshold 0) and `hi` (threshold 1). A three-bit mode field picks the rule that turns the gate on. The field has an enable bit and a two-bit selector. With one threshold, the gate can be on above `lo` or on at or below it. With two thresholds, the gate can be on strictly inside the window between `lo` and `hi`, or on outside it.

The gate output and a configuration-error flag are both registered, so each follows its inputs one clock later. A two-threshold mode needs `hi` to be strictly greater than `lo`. When that order is violated the error flag rises and the gate is held off. Nothing then depends on the undefined window. The count source and the output driver stage sit outside this block.

Top module: `gate_cmp_out`

## Requirements
- R1: While `rst_ni` is low, `gate_o` and `cfg_err_o` are 0.
- R2: `mode_i[0]` is the enable bit and `mode_i[2:1]` is the selector: 00 means above-lo, 01 means at-or-below-lo, 10 means inside-window and 11 means outside-window. When `mode_i[0]` is 0, `gate_o` is 0 and `cfg_err_o` is 0, whatever the selector holds.
- R3: In mode 001, `gate_o` is 1 exactly when `count_i > lo_i`. A count equal to `lo_i` gives 0.
- R4: In mode 011, `gate_o` is 1 exactly when `count_i <= lo_i`.
- R5: In mode 101 with `hi_i > lo_i`, `gate_o` is 1 exactly when `lo_i < count_i < hi_i`. A count equal to either threshold gives 0.
- R6: In mode 111 with `hi_i > lo_i`, `gate_o` is 1 exactly when `count_i <= lo_i` or `count_i >= hi_i`.
- R7: In modes 101 and 111, if `hi_i <= lo_i` then `cfg_err_o` is 1 and `gate_o` is 0. In modes 001 and 011, `cfg_err_o` is 0 whatever the value of `hi_i`.
- R8: `gate_o` and `cfg_err_o` take the values computed from the inputs sampled at a rising clock edge, and they do not change before that edge.
- R9: All comparisons are unsigned over the full 0 to 2^CNT_W-1 range, so a count with its top bit set ranks above every count whose top bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Bit 0 is the enable; bits 2:1 are the selector |
| count_i | input | CNT_W | Current count, unsigned |
| lo_i | input | CNT_W | Threshold 0 |
| hi_i | input | CNT_W | Threshold 1 |
| gate_o | output | 1 | Registered gate output |
| cfg_err_o | output | 1 | Registered flag for threshold order invalid in a window mode |

## Verification
All state in this block is the two output registers. A wrong comparison or a wrong selector decode therefore shows at `gate_o` one clock after the offending inputs are applied, and never later. The equality cases at `lo` and `hi` separate a strict from a non-strict compare. Counts with the top bit set separate unsigned from signed handling. A fault in the order check appears on `cfg_err_o` in the same cycle that the gate wrongly turns on.

// File: rtl/gate_cmp_pkg.sv
package gate_cmp_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [1:0] {
    GSEL_ABOVE   = 2'b00,
    GSEL_BELOW   = 2'b01,
    GSEL_INSIDE  = 2'b10,
    GSEL_OUTSIDE = 2'b11
  } gate_sel_e;

  typedef struct packed {
    logic      en;
    gate_sel_e sel;
  } mode_dec_t;

  typedef struct packed {
    logic gt_lo;     // count > lo
    logic lt_hi;     // count < hi
    logic order_ok;  // hi > lo
  } cmp_res_t;

endpackage

// File: rtl/gate_mode_dec.sv
module gate_mode_dec
  import gate_cmp_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_dec_t         dec_o
);

  always_comb begin
    dec_o.en  = mode_i[0];
    dec_o.sel = gate_sel_e'(mode_i[2:1]);
  end

endmodule

// File: rtl/gate_thr_cmp.sv
module gate_thr_cmp
  import gate_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output cmp_res_t         res_o
);

  // operands are unsigned logic vectors: no sign extension
  always_comb begin
    res_o.gt_lo    = count_i > lo_i;
    res_o.lt_hi    = count_i < hi_i;
    res_o.order_ok = hi_i > lo_i;
  end

endmodule

// File: rtl/gate_eval.sv
module gate_eval
  import gate_cmp_pkg::*;
(
  input  mode_dec_t dec_i,
  input  cmp_res_t  cmp_i,
  output logic      gate_d_o,
  output logic      err_d_o
);

  logic two_thr;
  logic in_win;
  logic raw_on;

  always_comb begin
    two_thr = dec_i.sel inside {GSEL_INSIDE, GSEL_OUTSIDE};
    in_win  = cmp_i.gt_lo & cmp_i.lt_hi;
    unique case (dec_i.sel)
      GSEL_ABOVE:   raw_on = cmp_i.gt_lo;
      GSEL_BELOW:   raw_on = ~cmp_i.gt_lo;
      GSEL_INSIDE:  raw_on = in_win;
      GSEL_OUTSIDE: raw_on = ~in_win;
      default:      raw_on = 1'b0;
    endcase
    err_d_o  = dec_i.en & two_thr & ~cmp_i.order_ok;
    gate_d_o = dec_i.en & raw_on & ~err_d_o;
  end

endmodule

// File: rtl/gate_cmp_out.sv
module gate_cmp_out
  import gate_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             gate_o,
  output logic             cfg_err_o
);

  mode_dec_t dec;
  cmp_res_t  cmp;
  logic      gate_d;
  logic      err_d;
  logic      past_vld_q;

  gate_mode_dec u_dec (
    .mode_i (mode_i),
    .dec_o  (dec)
  );

  gate_thr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .count_i (count_i),
    .lo_i    (lo_i),
    .hi_i    (hi_i),
    .res_o   (cmp)
  );

  gate_eval u_eval (
    .dec_i    (dec),
    .cmp_i    (cmp),
    .gate_d_o (gate_d),
    .err_d_o  (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o     <= 1'b0;
      cfg_err_o  <= 1'b0;
      past_vld_q <= 1'b0;
    end else begin
      gate_o     <= gate_d;
      cfg_err_o  <= err_d;
      past_vld_q <= 1'b1;
    end
  end

  p_off_when_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && !$past(mode_i[0])) |-> (!gate_o && !cfg_err_o));

  p_above_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && $past(mode_i) == 3'b001) |-> (gate_o == $past(count_i > lo_i)));

  p_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && $past(mode_i) == 3'b101 && $past(hi_i > lo_i))
      |-> (gate_o == $past(count_i > lo_i && count_i < hi_i)));

  p_err_gate_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !gate_o);

  p_single_no_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && !$past(mode_i[2])) |-> !cfg_err_o);

endmodule

// File: tb/gate_cmp_out_test.sv
module gate_cmp_out_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 32;

  typedef struct packed {
    logic [2:0]       mode;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    logic             gate;
    logic             err;
    logic [3:0]       req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{3'b001, 32'd100, 32'd50, 32'd0, 1'b1, 1'b0, 4'd3},  // R3
    '{3'b001, 32'd50,  32'd50, 32'd0, 1'b0, 1'b0, 4'd3},  // R3 equal
    '{3'b001, 32'd49,  32'd50, 32'd0, 1'b0, 1'b0, 4'd3},  // R3
    '{3'b011, 32'd50,  32'd50, 32'd0, 1'b1, 1'b0, 4'd4},  // R4 equal
    '{3'b011, 32'd51,  32'd50, 32'd0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'b011, 32'd0,   32'd0,  32'd9, 1'b1, 1'b0, 4'd4},  // R4
    '{3'b101, 32'd15,  32'd10, 32'd20, 1'b1, 1'b0, 4'd5}, // R5
    '{3'b101, 32'd10,  32'd10, 32'd20, 1'b0, 1'b0, 4'd5}, // R5 at lo
    '{3'b101, 32'd20,  32'd10, 32'd20, 1'b0, 1'b0, 4'd5}, // R5 at hi
    '{3'b101, 32'd21,  32'd10, 32'd20, 1'b0, 1'b0, 4'd5}, // R5
    '{3'b111, 32'd15,  32'd10, 32'd20, 1'b0, 1'b0, 4'd6}, // R6
    '{3'b111, 32'd10,  32'd10, 32'd20, 1'b1, 1'b0, 4'd6}, // R6 at lo
    '{3'b111, 32'd20,  32'd10, 32'd20, 1'b1, 1'b0, 4'd6}, // R6 at hi
    '{3'b111, 32'd5,   32'd10, 32'd20, 1'b1, 1'b0, 4'd6}, // R6
    '{3'b000, 32'd100, 32'd50, 32'd0,  1'b0, 1'b0, 4'd2}, // R2
    '{3'b110, 32'd5,   32'd10, 32'd20, 1'b0, 1'b0, 4'd2}, // R2
    '{3'b100, 32'd5,   32'd30, 32'd10, 1'b0, 1'b0, 4'd2}, // R2 bad order, disabled
    '{3'b010, 32'd0,   32'd5,  32'd9,  1'b0, 1'b0, 4'd2}, // R2
    '{3'b101, 32'd20,  32'd20, 32'd20, 1'b0, 1'b1, 4'd7}, // R7 hi==lo
    '{3'b111, 32'd5,   32'd30, 32'd10, 1'b0, 1'b1, 4'd7}, // R7 hi<lo
    '{3'b001, 32'd40,  32'd30, 32'd10, 1'b1, 1'b0, 4'd7}, // R7 single ignores hi
    '{3'b001, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 1'b1, 1'b0, 4'd9},        // R9
    '{3'b011, 32'hFFFF_FFFF, 32'd1,         32'd0, 1'b0, 1'b0, 4'd9},        // R9
    '{3'b101, 32'h8000_0000, 32'd0,         32'hFFFF_FFFF, 1'b1, 1'b0, 4'd9} // R9
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       mode_i = 3'b001;
  logic [CNT_W-1:0] count_i = '0;
  logic [CNT_W-1:0] lo_i = '0;
  logic [CNT_W-1:0] hi_i = '0;
  logic             gate_o;
  logic             cfg_err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gate_cmp_out #(.CNT_W(CNT_W)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .count_i   (count_i),
    .lo_i      (lo_i),
    .hi_i      (hi_i),
    .gate_o    (gate_o),
    .cfg_err_o (cfg_err_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [CNT_W-1:0] c,
                       input logic [CNT_W-1:0] l, input logic [CNT_W-1:0] h);
    @(negedge clk_i);
    mode_i = m; count_i = c; lo_i = l; hi_i = h;
  endtask

  initial begin
    // R1: reset state, inputs would otherwise turn gate on
    mode_i = 3'b011; count_i = 32'd0; lo_i = 32'd5; hi_i = 32'd0;
    repeat (3) @(negedge clk_i);
    chk("R1 gate in reset", gate_o, 1'b0);
    chk("R1 err in reset", cfg_err_o, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].mode, VEC[i].cnt, VEC[i].lo, VEC[i].hi);
      @(negedge clk_i);
      chk($sformatf("R%0d vec%0d gate", VEC[i].req, i), gate_o, VEC[i].gate);
      chk($sformatf("R%0d vec%0d err", VEC[i].req, i), cfg_err_o, VEC[i].err);
    end

    // R8: output holds until the next edge, then follows
    apply(3'b001, 32'd1, 32'd5, 32'd0);
    @(negedge clk_i);
    chk("R8 settle low", gate_o, 1'b0);
    count_i = 32'd9;
    #1;
    chk("R8 no change before edge", gate_o, 1'b0);
    @(negedge clk_i);
    chk("R8 change after one edge", gate_o, 1'b1);
    lo_i = 32'd9;
    #1;
    chk("R8 threshold change before edge", gate_o, 1'b1);
    @(negedge clk_i);
    chk("R8 threshold change after edge", gate_o, 1'b0);

    // R7: error clears once order is fixed
    apply(3'b101, 32'd15, 32'd20, 32'd10);
    @(negedge clk_i);
    chk("R7 err set", cfg_err_o, 1'b1);
    hi_i = 32'd30;
    @(negedge clk_i);
    chk("R7 err cleared", cfg_err_o, 1'b0);
    chk("R7 gate resumes", gate_o, 1'b0);
    count_i = 32'd25;
    @(negedge clk_i);
    chk("R7 gate resumes in window", gate_o, 1'b1);

    // R1: asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async clear", gate_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule